// File: doc/BRIEF.md
# Active Video Start Timing Generator

This block sits on the pixel input side of a video encoder. It finds the leading edge of horizontal sync and counts input clocks from that edge. It reports which clock of the current pixel is in progress, strobes once per pixel, and raises an active-data flag over the span of the line that carries real pixel data. The input clock can run at one, two or three times the pixel rate. The pixel boundaries are always re-aligned to sync, so the first active pixel lands a whole number of pixels after the sync edge. In the multiplied modes that means a multiple of two or three input clocks.

The start offset is a 9-bit pixel count. Its low byte and its top bit come from two separate register fields. The clock multiplier, the strobe placement, the offset and the active width are all captured only at a sync leading edge. A whole line therefore runs under one setting, and software can rewrite the fields at any time.

Top module: `avs_start_gen`

## Requirements
- R1: After reset and until the first sync leading edge, `phase_idx` is 0 and both `pix_stb` and `act_de` are low.
- R2: With `sync_pol`=1 the leading edge is a 0-to-1 change of `hsync_in`. With `sync_pol`=0 it is a 1-to-0 change. The opposite transition and a held level start nothing.
- R3: `clk_mode` selects the clocks per pixel (cpp): 2'b00 gives 1, 2'b01 gives 2, and 2'b10 or 2'b11 give 3. Clock 0 is the first clock after the edge that captures the sync leading edge. From clock 0 on, `phase_idx` equals the clock number modulo cpp.
- R4: With `latch_pos`=1, `pix_stb` is high exactly on clocks where `phase_idx` = cpp-1. With `latch_pos`=0, it is high exactly where `phase_idx` = 0.
- R5: The start offset N is {`ofs_hi`, `ofs_lo`}: `ofs_hi` is bit 8 and `ofs_lo` holds bits 7:0.
- R6: `act_de` first rises on clock N*cpp of the line. The number of clocks from the sync edge to the first active data is therefore a multiple of cpp.
- R7: `act_de` stays high for exactly `act_width`*cpp clocks. It never rises when `act_width` is 0.
- R8: `clk_mode`, `latch_pos`, `ofs_hi`, `ofs_lo` and `act_width` are sampled only on a sync leading edge. Changes made mid-line have no effect on the current line.
- R9: A new sync leading edge in the middle of a line restarts the phase and the pixel count. The offset is then measured from the new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input (multiplied) clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync |
| sync_pol | input | 1 | Sync polarity: 1 active high, 0 active low |
| clk_mode | input | 2 | Input clocks per pixel select |
| latch_pos | input | 1 | Strobe placement: 1 last clock of pixel, 0 first clock |
| ofs_lo | input | 8 | Start offset bits 7:0 |
| ofs_hi | input | 1 | Start offset bit 8 |
| act_width | input | ACT_W | Active width in pixels |
| phase_idx | output | 2 | Clock index inside the current pixel |
| pix_stb | output | 1 | One-clock pulse per pixel |
| act_de | output | 1 | Active pixel data flag |

## Verification
The sync input goes through one register. The phase and pixel counters are loaded on the edge where the leading edge is seen, and every output is decoded from those registers without further delay. A sync change driven before a rising edge therefore shows at the outputs on the clock right after that edge, which is clock 0 of the line. The bench drives inputs and samples outputs on falling edges. Its sample counter starts at that clock 0, so first-active positions and active lengths are compared directly against N*cpp and width*cpp. Mid-line register writes and a second sync edge are injected at known sample counts, so the expected restart point is fixed in clocks.

// File: rtl/avs_pkg.sv
package avs_pkg;

    // Clock multiplier codes; the upper bit set always means three clocks per pixel.
    typedef enum logic [1:0] {
        MUL_X1  = 2'b00,
        MUL_X2  = 2'b01,
        MUL_X3A = 2'b10,
        MUL_X3B = 2'b11
    } mul_mode_e;

    // Per-line pixel timing configuration.
    typedef struct packed {
        logic [1:0] cpp;        // input clocks per pixel, 1..3
        logic       late_edge;  // strobe on last clock of pixel when set
    } pix_cfg_t;

    function automatic logic [1:0] mul_to_cpp(input logic [1:0] code);
        logic [1:0] r;
        if (code[1])      r = 2'd3;
        else if (code[0]) r = 2'd2;
        else              r = 2'd1;
        return r;
    endfunction

    function automatic logic [1:0] strobe_phase(input pix_cfg_t c);
        return c.late_edge ? (c.cpp - 2'd1) : 2'd0;
    endfunction

endpackage

// File: rtl/avs_sync_edge.sv
module avs_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic hsync_in,
    input  logic sync_pol,
    output logic lead_o
);
    logic s_now;
    logic s_q;

    // Normalise to active-high.
    assign s_now = sync_pol ? hsync_in : ~hsync_in;

    // Reset to "asserted" so a sync already active at reset release is not an edge.
    always_ff @(posedge clk) begin
        if (rst) s_q <= 1'b1;
        else     s_q <= s_now;
    end

    assign lead_o = s_now & ~s_q;
endmodule

// File: rtl/avs_line_cfg.sv
module avs_line_cfg
    import avs_pkg::*;
#(
    parameter int OFS_LO_W = 8,
    parameter int ACT_W    = 11,
    localparam int OFS_W   = OFS_LO_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lead,
    input  logic [1:0]          mode,
    input  logic                late_edge,
    input  logic [OFS_LO_W-1:0] ofs_lo,
    input  logic                ofs_hi,
    input  logic [ACT_W-1:0]    width,
    output pix_cfg_t            cfg_o,
    output logic [OFS_W-1:0]    ofs_o,
    output logic [ACT_W-1:0]    width_o,
    output logic                running_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o     <= '{cpp: 2'd1, late_edge: 1'b0};
            ofs_o     <= '0;
            width_o   <= '0;
            running_o <= 1'b0;
        end else if (lead) begin
            cfg_o.cpp       <= mul_to_cpp(mode);
            cfg_o.late_edge <= late_edge;
            ofs_o           <= {ofs_hi, ofs_lo};
            width_o         <= width;
            running_o       <= 1'b1;
        end
    end
endmodule

// File: rtl/avs_pixel_phase.sv
module avs_pixel_phase
    import avs_pkg::*;
#(
    parameter int PIX_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lead,
    input  logic             running,
    input  pix_cfg_t         cfg,
    output logic [1:0]       phase_o,
    output logic             strobe_o,
    output logic [PIX_W-1:0] pix_o
);
    logic [1:0]       phase_q;
    logic [PIX_W-1:0] pix_q;
    logic             wrap;

    assign wrap = (phase_q == cfg.cpp - 2'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 2'd0;
            pix_q   <= '0;
        end else if (lead) begin
            phase_q <= 2'd0;
            pix_q   <= '0;
        end else if (running) begin
            if (wrap) begin
                phase_q <= 2'd0;
                if (pix_q != {PIX_W{1'b1}}) pix_q <= pix_q + 1'b1;
            end else begin
                phase_q <= phase_q + 2'd1;
            end
        end
    end

    assign phase_o  = phase_q;
    assign pix_o    = pix_q;
    assign strobe_o = running && (phase_q == strobe_phase(cfg));
endmodule

// File: rtl/avs_active_win.sv
module avs_active_win #(
    parameter int OFS_W = 9,
    parameter int ACT_W = 11,
    parameter int PIX_W = 12
) (
    input  logic             running,
    input  logic [PIX_W-1:0] pix,
    input  logic [OFS_W-1:0] ofs,
    input  logic [ACT_W-1:0] width,
    output logic             de_o
);
    logic [PIX_W-1:0] start_px;
    logic [PIX_W-1:0] stop_px;

    always_comb begin
        start_px = PIX_W'(ofs);
        stop_px  = PIX_W'(ofs) + PIX_W'(width);
        de_o     = running && (pix >= start_px) && (pix < stop_px);
    end
endmodule

// File: rtl/avs_start_gen.sv
module avs_start_gen
    import avs_pkg::*;
#(
    parameter int OFS_LO_W = 8,
    parameter int ACT_W    = 11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hsync_in,
    input  logic                sync_pol,
    input  logic [1:0]          clk_mode,
    input  logic                latch_pos,
    input  logic [OFS_LO_W-1:0] ofs_lo,
    input  logic                ofs_hi,
    input  logic [ACT_W-1:0]    act_width,
    output logic [1:0]          phase_idx,
    output logic                pix_stb,
    output logic                act_de
);
    localparam int OFS_W = OFS_LO_W + 1;
    localparam int PIX_W = ((OFS_W > ACT_W) ? OFS_W : ACT_W) + 1;

    logic             lead;
    logic             running;
    pix_cfg_t         cfg_q;
    logic [OFS_W-1:0] ofs_q;
    logic [ACT_W-1:0] width_q;
    logic [PIX_W-1:0] pix;

    avs_sync_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .hsync_in (hsync_in),
        .sync_pol (sync_pol),
        .lead_o   (lead)
    );

    avs_line_cfg #(.OFS_LO_W(OFS_LO_W), .ACT_W(ACT_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .lead      (lead),
        .mode      (clk_mode),
        .late_edge (latch_pos),
        .ofs_lo    (ofs_lo),
        .ofs_hi    (ofs_hi),
        .width     (act_width),
        .cfg_o     (cfg_q),
        .ofs_o     (ofs_q),
        .width_o   (width_q),
        .running_o (running)
    );

    avs_pixel_phase #(.PIX_W(PIX_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .lead     (lead),
        .running  (running),
        .cfg      (cfg_q),
        .phase_o  (phase_idx),
        .strobe_o (pix_stb),
        .pix_o    (pix)
    );

    avs_active_win #(.OFS_W(OFS_W), .ACT_W(ACT_W), .PIX_W(PIX_W)) u_win (
        .running (running),
        .pix     (pix),
        .ofs     (ofs_q),
        .width   (width_q),
        .de_o    (act_de)
    );
endmodule

// File: rtl/avs_start_gen_chk.sv
module avs_start_gen_chk
    import avs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       lead,
    input logic       running,
    input pix_cfg_t   cfg,
    input logic [1:0] phase_idx,
    input logic       pix_stb,
    input logic       act_de
);
    // R1: quiet until the first sync edge
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !running |-> (phase_idx == 2'd0 && !pix_stb && !act_de));

    // R3: phase advances by one until the last clock of the pixel
    a_r3_phase_step: assert property (@(posedge clk) disable iff (rst)
        (running && !lead && phase_idx != cfg.cpp - 2'd1) |=> phase_idx == $past(phase_idx) + 2'd1);

    // R3: phase stays below the clocks-per-pixel count
    a_r3_phase_range: assert property (@(posedge clk) disable iff (rst)
        running |-> phase_idx < cfg.cpp);

    // R6: active data only starts on a pixel boundary
    a_r6_de_on_boundary: assert property (@(posedge clk) disable iff (rst)
        $rose(act_de) |-> phase_idx == 2'd0);

    // R8: configuration only changes at a sync leading edge
    a_r8_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !lead |=> $stable(cfg));

    // R9: a sync leading edge restarts the phase
    a_r9_restart: assert property (@(posedge clk) disable iff (rst)
        lead |=> phase_idx == 2'd0);
endmodule

bind avs_start_gen avs_start_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .lead      (lead),
    .running   (running),
    .cfg       (cfg_q),
    .phase_idx (phase_idx),
    .pix_stb   (pix_stb),
    .act_de    (act_de)
);

// File: tb/avs_start_gen_test.sv
`timescale 1ns/1ps
module avs_start_gen_test;
    localparam int ACT_W = 11;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             hsync_in = 1'b0;
    logic             sync_pol = 1'b1;
    logic [1:0]       clk_mode = 2'b00;
    logic             latch_pos = 1'b1;
    logic [7:0]       ofs_lo = 8'd0;
    logic             ofs_hi = 1'b0;
    logic [ACT_W-1:0] act_width = '0;
    logic [1:0]       phase_idx;
    logic             pix_stb;
    logic             act_de;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    avs_start_gen #(.OFS_LO_W(8), .ACT_W(ACT_W)) uut (
        .clk, .rst, .hsync_in, .sync_pol, .clk_mode, .latch_pos,
        .ofs_lo, .ofs_hi, .act_width, .phase_idx, .pix_stb, .act_de
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic        late;
        logic        hi;
        logic [7:0]  lo;
        logic [10:0] width;
        int          first;   // expected first active clock, -1 = never
        int          len;     // expected active clocks
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{2'b00, 1'b1, 1'b0, 8'd5, 11'd4,   5,  4},
        '{2'b01, 1'b1, 1'b0, 8'd3, 11'd2,   6,  4},
        '{2'b10, 1'b0, 1'b0, 8'd2, 11'd3,   6,  9},
        '{2'b11, 1'b1, 1'b1, 8'd0, 11'd1, 768,  3},
        '{2'b01, 1'b0, 1'b0, 8'd0, 11'd5,   0, 10},
        '{2'b00, 1'b1, 1'b0, 8'd7, 11'd0,  -1,  0}
    };

    function automatic int cpp_of(input logic [1:0] m);
        return m[1] ? 3 : (m[0] ? 2 : 1);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    // hook: 0 none, 1 rewrite config at clock 1, 2 new sync edge at clock 10
    task automatic run_line(input int cpp, input bit late, input int maxc, input int hook,
                            output int first, output int len, output int perr, output int serr);
        int base;
        int k;
        int exp_ph;
        bit exp_s;
        base = 0; first = -1; len = 0; perr = 0; serr = 0;
        for (int c = 0; c < maxc; c++) begin
            @(negedge clk);
            k = c - base;
            exp_ph = k % cpp;
            exp_s  = (exp_ph == (late ? cpp - 1 : 0));
            if (int'(phase_idx) != exp_ph) perr++;
            if (pix_stb != exp_s) serr++;
            if (act_de) begin
                if (first < 0) first = k;
                len++;
            end
            if (k == 3) hsync_in = ~sync_pol;
            if (hook == 1 && c == 1) begin
                clk_mode = 2'b10; ofs_lo = 8'd10; act_width = 11'd9; latch_pos = 1'b0;
            end
            if (hook == 2 && c == 10) begin
                hsync_in = sync_pol;
                base = 11; first = -1; len = 0;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_up();
    end

    initial begin
        int first, len, perr, serr, nz_ph, nz_s, nz_de;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        nz_ph = 0; nz_s = 0; nz_de = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (phase_idx != 2'd0) nz_ph++;
            if (pix_stb) nz_s++;
            if (act_de) nz_de++;
        end
        chk("R1", "idle phase nonzero count", nz_ph, 0);
        chk("R1", "idle strobe count", nz_s, 0);
        chk("R1", "idle active count", nz_de, 0);

        // Table of lines
        for (int v = 0; v < 6; v++) begin
            @(negedge clk);
            clk_mode = VEC[v].mode; latch_pos = VEC[v].late;
            ofs_hi = VEC[v].hi; ofs_lo = VEC[v].lo; act_width = VEC[v].width;
            hsync_in = 1'b1;
            run_line(cpp_of(VEC[v].mode), VEC[v].late, 1000, 0, first, len, perr, serr);
            chk(v == 3 ? "R5/R6" : "R6", $sformatf("vec%0d first active clock", v), first, VEC[v].first);
            chk("R7", $sformatf("vec%0d active length", v), len, VEC[v].len);
            chk("R3", $sformatf("vec%0d phase mismatches", v), perr, 0);
            chk("R4", $sformatf("vec%0d strobe mismatches", v), serr, 0);
        end

        // R8: mid-line rewrite is ignored
        @(negedge clk);
        clk_mode = 2'b00; latch_pos = 1'b1; ofs_hi = 1'b0; ofs_lo = 8'd4; act_width = 11'd3;
        hsync_in = 1'b1;
        run_line(1, 1'b1, 60, 1, first, len, perr, serr);
        chk("R8", "first active after rewrite", first, 4);
        chk("R8", "length after rewrite", len, 3);
        chk("R8", "phase mismatches after rewrite", perr + serr, 0);

        // R9: second sync edge mid-line restarts counting
        @(negedge clk);
        clk_mode = 2'b00; latch_pos = 1'b1; ofs_hi = 1'b0; ofs_lo = 8'd20; act_width = 11'd2;
        hsync_in = 1'b1;
        run_line(1, 1'b1, 80, 2, first, len, perr, serr);
        chk("R9", "first active after restart", first, 20);
        chk("R9", "length after restart", len, 2);

        // R2: active-low sync; rising hsync must not restart
        @(negedge clk);
        sync_pol = 1'b0; hsync_in = 1'b1;
        repeat (3) @(negedge clk);
        clk_mode = 2'b01; latch_pos = 1'b1; ofs_lo = 8'd1; act_width = 11'd1;
        hsync_in = 1'b0;
        run_line(2, 1'b1, 40, 0, first, len, perr, serr);
        chk("R2", "falling edge first active", first, 2);
        chk("R2", "no restart on inactive edge, length", len, 2);
        chk("R2", "phase mismatches", perr, 0);

        finish_up();
    end
endmodule